// File: doc/BRIEF.md
# Variable Product-Term AND-OR Array

This block is the logic core of a small programmable logic device. Its array columns come from two sources: the dedicated logic inputs and the feedback lines of the output macrocells. Each signal supplies a true column and a complement column. A product term is the AND of every literal that its configuration row selects. Each output then ORs its own group of product terms. The group sizes differ from output to output: they start small at the outer outputs and grow towards the middle. Beside the logic terms, the array has one enable term for each output, one shared asynchronous-reset term and one shared synchronous-preset term. These go to the macrocells that sit downstream.

The configuration is held inside the block. There are two ways to load it. One is a row-write port that replaces a single term's column mask in one clock. The other is a serial shift input that streams the whole vector one bit per clock. Reset clears the configuration. Evaluation of the array is purely combinational, so the outputs follow the inputs and the feedback within the same cycle. Macrocell registers, output polarity and pin drivers lie outside this block.

Top module: `pla_array`

## Requirements
- R1: Signal s is dedicated input s for s < N_IN and feedback line s-N_IN above that. Column 2s of a term row is the true literal of signal s and column 2s+1 is its complement. A term is 1 exactly when every literal whose configuration bit is 1 is itself 1.
- R2: A term whose row bits are all 0 evaluates to 1.
- R3: A term that selects both the true and the complement column of the same signal evaluates to 0 for every input.
- R4: Output o ORs PT_BASE + PT_STEP*min(o, N_OUT-1-o) logic terms. With the defaults this gives 8,10,12,14,16,16,14,12,10,8.
- R5: The term indices are laid out as follows. Term 0 drives areset_o. Each output o, in ascending order, then takes one enable term followed by its logic terms. The last term drives spreset_o. Term t occupies configuration bits t*COLS to t*COLS+COLS-1, where COLS = 2*(N_IN+N_OUT).
- R6: oe_o[o] equals the enable term of output o.
- R7: When cfg_wr_i is 1 and cfg_shift_i is 0 at a rising clock edge, the row of term cfg_addr_i is replaced by cfg_row_i. Bit c of cfg_row_i is column c.
- R8: When cfg_shift_i is 1 at a rising edge, the whole configuration shifts one place towards bit 0 and cfg_sdi_i enters the top bit. After total-bit-count shifts, the first bit sent sits at bit 0.
- R9: If shift and row write are requested in the same cycle, the shift is performed and the write is dropped.
- R10: A row write whose address is not below the term count leaves the configuration unchanged.
- R11: While rst_ni is low, and after it rises, the configuration is all zero until it is loaded. In that state every output reads 1.
- R12: Every output is a combinational function of in_i, fb_i and the stored configuration. No clock edge is needed between an input change and the output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration store |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the configuration |
| in_i | input | N_IN (12) | Dedicated logic inputs |
| fb_i | input | N_OUT (10) | Macrocell feedback lines |
| cfg_wr_i | input | 1 | Row write strobe |
| cfg_addr_i | input | AW (8) | Term index for a row write |
| cfg_row_i | input | COLS (44) | Column mask written to the addressed term |
| cfg_shift_i | input | 1 | Serial shift strobe |
| cfg_sdi_i | input | 1 | Serial configuration data in |
| sum_o | output | N_OUT (10) | OR of each output's logic terms |
| oe_o | output | N_OUT (10) | Per-output enable term |
| areset_o | output | 1 | Shared asynchronous-reset term |
| spreset_o | output | 1 | Shared synchronous-preset term |

## Verification
The checker's properties assume that the loading strobes and the data are stable at each rising edge, and that rst_ni is the only source of asynchronous change in the stored configuration. The hold property also assumes that in_i and fb_i change only between sampled edges. The bench drives every input at the falling edge and holds it through the next rising edge. It keeps cfg_wr_i and cfg_shift_i low during every evaluation sweep, so a configuration change never coincides with an input change. The one exception is the cycle that tests write priority, which asserts both strobes on purpose.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  // logic terms ORed into output o
  function automatic int pt_cnt(int o, int n_out, int base, int step);
    int k;
    k = (o < n_out - 1 - o) ? o : n_out - 1 - o;
    return base + step * k;
  endfunction

  // index of the enable term of output o; its logic terms follow
  function automatic int blk_base(int o, int n_out, int base, int step);
    int b;
    b = 1;
    for (int j = 0; j < o; j++) b += 1 + pt_cnt(j, n_out, base, step);
    return b;
  endfunction

  function automatic int term_total(int n_out, int base, int step);
    return blk_base(n_out, n_out, base, step) + 1;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
module pla_cfg_store #(
  parameter int TERMS = 132,
  parameter int COLS  = 44,
  parameter int AW    = 8,
  localparam int TOT  = TERMS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [COLS-1:0] row_i,
  input  logic            shift_i,
  input  logic            sdi_i,
  output logic [TOT-1:0]  cfg_o
);

  logic [TOT-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (shift_i) begin
      cfg_q <= {sdi_i, cfg_q[TOT-1:1]};
    end else if (wr_i) begin
      for (int t = 0; t < TERMS; t++) begin
        if (addr_i == AW'(t)) cfg_q[t*COLS +: COLS] <= row_i;
      end
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int TERMS = 132,
  parameter int N_SIG = 22,
  localparam int COLS = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]       sig_i,
  input  logic [TERMS*COLS-1:0]  cfg_i,
  output logic [TERMS-1:0]       pt_o
);

  logic [COLS-1:0] lit;

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[2*s]   = sig_i[s];
    assign lit[2*s+1] = ~sig_i[s];
  end

  // unselected columns read as 1
  for (genvar t = 0; t < TERMS; t++) begin : g_term
    assign pt_o[t] = &(~cfg_i[t*COLS +: COLS] | lit);
  end

endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int N_OUT   = 10,
  parameter int PT_BASE = 8,
  parameter int PT_STEP = 2,
  localparam int TERMS  = pla_pkg::term_total(N_OUT, PT_BASE, PT_STEP)
) (
  input  logic [TERMS-1:0] pt_i,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o,
  output logic             areset_o,
  output logic             spreset_o
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int B = pla_pkg::blk_base(o, N_OUT, PT_BASE, PT_STEP);
    localparam int C = pla_pkg::pt_cnt(o, N_OUT, PT_BASE, PT_STEP);
    assign oe_o[o]  = pt_i[B];
    assign sum_o[o] = |pt_i[B+1 +: C];
  end

  assign areset_o  = pt_i[0];
  assign spreset_o = pt_i[TERMS-1];

endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array #(
  parameter int N_IN    = 12,
  parameter int N_OUT   = 10,
  parameter int PT_BASE = 8,
  parameter int PT_STEP = 2,
  localparam int N_SIG  = N_IN + N_OUT,
  localparam int COLS   = 2 * N_SIG,
  localparam int TERMS  = pla_pkg::term_total(N_OUT, PT_BASE, PT_STEP),
  localparam int AW     = $clog2(TERMS),
  localparam int TOT    = TERMS * COLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_OUT-1:0] fb_i,
  input  logic             cfg_wr_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [COLS-1:0]  cfg_row_i,
  input  logic             cfg_shift_i,
  input  logic             cfg_sdi_i,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o,
  output logic             areset_o,
  output logic             spreset_o
);

  logic [TOT-1:0]   cfg_q;
  logic [TERMS-1:0] pt_w;

  pla_cfg_store #(.TERMS(TERMS), .COLS(COLS), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .addr_i  (cfg_addr_i),
    .row_i   (cfg_row_i),
    .shift_i (cfg_shift_i),
    .sdi_i   (cfg_sdi_i),
    .cfg_o   (cfg_q)
  );

  pla_and_plane #(.TERMS(TERMS), .N_SIG(N_SIG)) u_and (
    .sig_i (({fb_i, in_i})),
    .cfg_i (cfg_q),
    .pt_o  (pt_w)
  );

  pla_or_plane #(.N_OUT(N_OUT), .PT_BASE(PT_BASE), .PT_STEP(PT_STEP)) u_or (
    .pt_i      (pt_w),
    .sum_o     (sum_o),
    .oe_o      (oe_o),
    .areset_o  (areset_o),
    .spreset_o (spreset_o)
  );

endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk #(
  parameter int N_IN    = 12,
  parameter int N_OUT   = 10,
  parameter int PT_BASE = 8,
  parameter int PT_STEP = 2,
  localparam int N_SIG  = N_IN + N_OUT,
  localparam int COLS   = 2 * N_SIG,
  localparam int TERMS  = pla_pkg::term_total(N_OUT, PT_BASE, PT_STEP),
  localparam int AW     = $clog2(TERMS),
  localparam int TOT    = TERMS * COLS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_IN-1:0]  in_i,
  input logic [N_OUT-1:0] fb_i,
  input logic             cfg_wr_i,
  input logic [AW-1:0]    cfg_addr_i,
  input logic [COLS-1:0]  cfg_row_i,
  input logic             cfg_shift_i,
  input logic             cfg_sdi_i,
  input logic [TOT-1:0]   cfg_q,
  input logic [TERMS-1:0] pt_w,
  input logic [N_OUT-1:0] sum_o,
  input logic [N_OUT-1:0] oe_o,
  input logic             areset_o
);

  // R8
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_shift_i |=> (cfg_q[TOT-1] == $past(cfg_sdi_i)) &&
                    (cfg_q[TOT-2:0] == $past(cfg_q[TOT-1:1])));

  // R10
  oor_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !cfg_shift_i && int'(cfg_addr_i) >= TERMS) |=> $stable(cfg_q));

  // R3
  contra_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[1:0] == 2'b11) |-> !areset_o);

  // R12
  comb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(in_i) && $stable(fb_i) && $stable(cfg_q)) |-> ($stable(sum_o) && $stable(oe_o)));

  for (genvar t = 0; t < TERMS; t++) begin : g_wr
    // R7
    row_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && !cfg_shift_i && cfg_addr_i == AW'(t)) |=>
        cfg_q[t*COLS +: COLS] == $past(cfg_row_i));
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    localparam int B = pla_pkg::blk_base(o, N_OUT, PT_BASE, PT_STEP);
    localparam int C = pla_pkg::pt_cnt(o, N_OUT, PT_BASE, PT_STEP);
    // R4
    or_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sum_o[o] |-> (pt_w[B+1 +: C] == '0));
  end

endmodule

bind pla_array pla_array_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .PT_BASE(PT_BASE), .PT_STEP(PT_STEP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_i        (in_i),
  .fb_i        (fb_i),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_row_i   (cfg_row_i),
  .cfg_shift_i (cfg_shift_i),
  .cfg_sdi_i   (cfg_sdi_i),
  .cfg_q       (cfg_q),
  .pt_w        (pt_w),
  .sum_o       (sum_o),
  .oe_o        (oe_o),
  .areset_o    (areset_o)
);

// File: tb/pla_array_bench.sv
`timescale 1ns/1ps
module pla_array_bench;

  localparam int N_IN  = 3;
  localparam int N_OUT = 4;
  localparam int BASE  = 2;
  localparam int STEP  = 2;
  localparam int N_SIG = N_IN + N_OUT;
  localparam int COLS  = 2 * N_SIG;        // 14
  localparam int TERMS = 18;               // 1 + (1+2)+(1+4)+(1+4)+(1+2) + 1
  localparam int AW    = 5;
  localparam int TOT   = TERMS * COLS;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_IN-1:0]  in_i = '0;
  logic [N_OUT-1:0] fb_i = '0;
  logic             cfg_wr_i = 1'b0;
  logic [AW-1:0]    cfg_addr_i = '0;
  logic [COLS-1:0]  cfg_row_i = '0;
  logic             cfg_shift_i = 1'b0;
  logic             cfg_sdi_i = 1'b0;
  logic [N_OUT-1:0] sum_o, oe_o;
  logic             areset_o, spreset_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [TOT-1:0] m = '0;
  logic [31:0] seed = 32'h1ace_b00c;

  always #2 clk = ~clk;

  pla_array #(.N_IN(N_IN), .N_OUT(N_OUT), .PT_BASE(BASE), .PT_STEP(STEP)) u_pla_array (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(in_i), .fb_i(fb_i),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_row_i(cfg_row_i),
    .cfg_shift_i(cfg_shift_i), .cfg_sdi_i(cfg_sdi_i),
    .sum_o(sum_o), .oe_o(oe_o), .areset_o(areset_o), .spreset_o(spreset_o)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic int cnt_of(int o);
    int k;
    k = (o < N_OUT - 1 - o) ? o : N_OUT - 1 - o;
    return BASE + STEP * k;
  endfunction

  function automatic logic pt_eval(int t, logic [N_SIG-1:0] sig);
    logic r;
    r = 1'b1;
    for (int c = 0; c < COLS; c++)
      if (m[t*COLS + c]) r = r & ((c % 2 == 1) ? ~sig[c/2] : sig[c/2]);
    return r;
  endfunction

  task automatic check(input logic ok, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m = '0;
  endtask

  task automatic write_row(input int t, input logic [COLS-1:0] row);
    @(negedge clk);
    cfg_wr_i = 1'b1;
    cfg_addr_i = AW'(t);
    cfg_row_i = row;
    if (t < TERMS) m[t*COLS +: COLS] = row;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << N_SIG); v++) begin
      logic [N_SIG-1:0] sig;
      logic [N_OUT-1:0] es, eo;
      logic ea, ep;
      int b;
      sig = N_SIG'(v);
      @(negedge clk);
      in_i = sig[N_IN-1:0];
      fb_i = sig[N_SIG-1:N_IN];
      b = 1;
      for (int o = 0; o < N_OUT; o++) begin
        logic s;
        s = 1'b0;
        eo[o] = pt_eval(b, sig);
        for (int k = 1; k <= cnt_of(o); k++) s = s | pt_eval(b + k, sig);
        es[o] = s;
        b += 1 + cnt_of(o);
      end
      ea = pt_eval(0, sig);
      ep = pt_eval(TERMS - 1, sig);
      #1;
      check({sum_o, oe_o, areset_o, spreset_o} == {es, eo, ea, ep},
            $sformatf("%s (R12 same-cycle) sig=%h got sum=%h oe=%h ar=%b sp=%b exp sum=%h oe=%h ar=%b sp=%b",
                      tag, sig, sum_o, oe_o, areset_o, spreset_o, es, eo, ea, ep));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired: got hung run exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R11: reset state, all terms unprogrammed
    @(negedge clk);
    in_i = 3'b101;
    fb_i = 4'b0110;
    #1;
    check({sum_o, oe_o, areset_o, spreset_o} == '1,
          $sformatf("R11 in reset got %h exp all ones", {sum_o, oe_o, areset_o, spreset_o}));
    do_reset();
    sweep("R2 R11 blank config");

    // R1: complement literal of in_i[1] on term 0
    write_row(0, 14'b00_0000_0000_1000);
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      in_i = v[0] ? 3'b010 : 3'b000;
      #1;
      check(areset_o == !v[0], $sformatf("R1 complement literal got %b exp %b", areset_o, !v[0]));
    end
    // R3: true and complement of signal 0 together
    write_row(0, 14'b00_0000_0000_0011);
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      in_i = 3'(v);
      #1;
      check(areset_o == 1'b0, $sformatf("R3 contradictory term got %b exp 0", areset_o));
    end

    // R4 R6: only the last logic term of each group is live
    for (int o = 0; o < N_OUT; o++) begin
      int b;
      do_reset();
      b = 1;
      for (int j = 0; j < o; j++) b += 1 + cnt_of(j);
      write_row(b, 14'b11);
      for (int k = 1; k < cnt_of(o); k++) write_row(b + k, 14'b11);
      write_row(b + cnt_of(o), 14'b01);
      for (int v = 0; v < 2; v++) begin
        @(negedge clk);
        in_i = 3'(v);
        #1;
        check(sum_o[o] == v[0], $sformatf("R4 out %0d last term got %b exp %b", o, sum_o[o], v[0]));
        check(oe_o[o] == 1'b0, $sformatf("R6 out %0d enable got %b exp 0", o, oe_o[o]));
      end
    end

    // R5 R7: random sparse rows through the write port
    for (int r = 0; r < 3; r++) begin
      do_reset();
      for (int t = 0; t < TERMS; t++) write_row(t, COLS'(rnd() & rnd() & rnd()));
      sweep("R5 R7 row-written config");
    end

    // R10: writes past the last term
    for (int t = TERMS; t < 32; t++) write_row(t, '1);
    sweep("R10 out-of-range writes");

    // R8: full serial load
    do_reset();
    @(negedge clk);
    cfg_shift_i = 1'b1;
    for (int i = 0; i < TOT; i++) begin
      cfg_sdi_i = (rnd() & 32'h7) == 0;
      m = {cfg_sdi_i, m[TOT-1:1]};
      @(negedge clk);
    end
    cfg_shift_i = 1'b0;
    sweep("R8 shifted config");

    // R9: shift wins over a same-cycle write
    do_reset();
    @(negedge clk);
    cfg_shift_i = 1'b1;
    cfg_sdi_i = 1'b0;
    cfg_wr_i = 1'b1;
    cfg_addr_i = '0;
    cfg_row_i = 14'b11;
    @(negedge clk);
    cfg_shift_i = 1'b0;
    cfg_wr_i = 1'b0;
    in_i = '0;
    #1;
    check(areset_o == 1'b1, $sformatf("R9 shift priority got %b exp 1", areset_o));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule